// File: doc/BRIEF.md
# Forwarded Load Value Queue

In redundant execution, a leading core retires loads and sends each loaded value, together with the address it came from, to a trailing core that runs the same instruction stream. This queue sits in the trailing core and holds those forwarded pairs. Each trailing load knows at decode which entry it will consume. The value is therefore handed out in program order at dispatch, before the trailing core has computed any address. The destination register can be written early, and loads that depend on it can issue without waiting.

The trailing core computes the effective address later and presents it on a separate verify port. The queue compares it with the address the leading core forwarded for the same entry. It never uses that address to find a value. A mismatch sets an error flag that stays set. An entry holds its slot until it has been verified. The count of held entries is exported to a voltage and frequency controller, which can use it to judge how far the trailing core lags. A flush input empties the queue when execution rolls back to a checkpoint.

Top module: `fwd_load_queue`

## Requirements
- R1: After synchronous reset, `occupancy` is 0, `enq_ready` is 1, and `disp_ready`, `ver_ready`, `disp_vld`, `chk_done`, `chk_mismatch` and `err_sticky` are 0.
- R2: Values leave in the order they were accepted. When `disp_req` and `disp_ready` are both high at a clock edge, `disp_vld` is high in the following cycle and `disp_value` holds the oldest value not yet dispatched. In every other cycle `disp_vld` is low.
- R3: `disp_ready` is low whenever every held entry has already been dispatched. A `disp_req` while `disp_ready` is low has no effect.
- R4: A verify is accepted when `ver_valid` and `ver_ready` are both high at an edge. `ver_ready` is high only while some entry has been dispatched but not yet verified. Verifies compare `ver_addr` with the forwarded addresses in dispatch order. One cycle after the accepting edge, `chk_done` pulses high, and `chk_mismatch` goes high with it if the two addresses differ.
- R5: `err_sticky` goes high at the same edge as the first mismatch. It then stays high until reset or flush.
- R6: `occupancy` counts entries that have been accepted but not yet verified. It goes up at an accepted enqueue and down at an accepted verify, and never exceeds DEPTH.
- R7: `enq_ready` is low exactly when `occupancy` equals DEPTH. An `enq_valid` while `enq_ready` is low is ignored.
- R8: A flush clears every count, both output pulses and `err_sticky` at that edge. Any enqueue, dispatch or verify presented in the same cycle is ignored.
- R9: An enqueue, a dispatch and a verify accepted at the same edge all take effect, and the net change in `occupancy` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue for a rollback |
| enq_valid | input | 1 | Forwarded pair present |
| enq_value | input | DATA_W | Forwarded load value |
| enq_addr | input | ADDR_W | Address the leading core loaded from |
| enq_ready | output | 1 | A free slot exists |
| disp_req | input | 1 | Trailing load dispatching |
| disp_ready | output | 1 | An undispatched entry exists |
| disp_vld | output | 1 | `disp_value` valid this cycle |
| disp_value | output | DATA_W | Value for the destination register |
| ver_valid | input | 1 | Trailing effective address present |
| ver_addr | input | ADDR_W | Trailing effective address |
| ver_ready | output | 1 | A dispatched, unverified entry exists |
| chk_done | output | 1 | Comparison result valid |
| chk_mismatch | output | 1 | Comparison found the addresses differ |
| err_sticky | output | 1 | Some mismatch since reset or flush |
| occupancy | output | $clog2(DEPTH+1) | Entries held, for the frequency controller |

## Verification
The bench fills the queue to the last slot and keeps offering enqueues there. A design with an off-by-one full test would either overwrite the oldest unverified entry or refuse the last slot. It also requests dispatch and verify on an empty queue. A design that does not stall would hand out a stale value, or move a pointer out of step with the stored data. Long random mixes, with occasional wrong trailing addresses, show up three kinds of fault: verify and dispatch pointers that drift apart, an error flag that clears itself, and an occupancy that is freed at dispatch instead of at verify. Flushes in the middle of traffic and cycles that fire all three ports at once check that nothing stale survives a rollback, and that concurrent updates to the counts do not lose one another.

// File: rtl/lvq_pkg.sv
package lvq_pkg;
  typedef struct packed {
    logic enq;
    logic disp;
    logic ver;
  } lvq_fire_t;
endpackage

// File: rtl/lvq_ram.sv
module lvq_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, holds its value when not enabled
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lvq_ctrl.sv
module lvq_ctrl
  import lvq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          enq_valid,
  input  logic          disp_req,
  input  logic          ver_valid,
  output lvq_fire_t     fire,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] vptr,
  output logic          enq_ready,
  output logic          disp_ready,
  output logic          ver_ready,
  output logic [CW-1:0] occupancy
);
  logic [CW-1:0] pend_q;
  logic [CW-1:0] tot_n, pend_n;

  always_comb begin
    fire.enq  = enq_valid & enq_ready & ~flush;
    fire.disp = disp_req  & disp_ready & ~flush;
    fire.ver  = ver_valid & ver_ready  & ~flush;
    tot_n  = occupancy + CW'(fire.enq) - CW'(fire.ver);
    pend_n = pend_q    + CW'(fire.enq) - CW'(fire.disp);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr       <= '0;
      rptr       <= '0;
      vptr       <= '0;
      occupancy  <= '0;
      pend_q     <= '0;
      enq_ready  <= 1'b1;
      disp_ready <= 1'b0;
      ver_ready  <= 1'b0;
    end else begin
      if (fire.enq)  wptr <= wptr + 1'b1;
      if (fire.disp) rptr <= rptr + 1'b1;
      if (fire.ver)  vptr <= vptr + 1'b1;
      occupancy  <= tot_n;
      pend_q     <= pend_n;
      enq_ready  <= (tot_n != CW'(DEPTH));
      disp_ready <= (pend_n != '0);
      ver_ready  <= (tot_n != pend_n);
    end
  end
endmodule

// File: rtl/lvq_check.sv
module lvq_check #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              start,
  input  logic [ADDR_W-1:0] fwd_addr,
  input  logic [ADDR_W-1:0] trl_addr,
  output logic              chk_done,
  output logic              chk_mismatch,
  output logic              err_sticky
);
  logic              stg;
  logic [ADDR_W-1:0] trl_q;
  logic              diff;

  assign diff = stg && (fwd_addr != trl_q);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      stg          <= 1'b0;
      trl_q        <= '0;
      chk_done     <= 1'b0;
      chk_mismatch <= 1'b0;
      err_sticky   <= 1'b0;
    end else begin
      stg          <= start;
      if (start) trl_q <= trl_addr;
      chk_done     <= stg;
      chk_mismatch <= diff;
      err_sticky   <= err_sticky | diff;
    end
  end
endmodule

// File: rtl/fwd_load_queue.sv
module fwd_load_queue
  import lvq_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              enq_valid,
  input  logic [DATA_W-1:0] enq_value,
  input  logic [ADDR_W-1:0] enq_addr,
  output logic              enq_ready,
  input  logic              disp_req,
  output logic              disp_ready,
  output logic              disp_vld,
  output logic [DATA_W-1:0] disp_value,
  input  logic              ver_valid,
  input  logic [ADDR_W-1:0] ver_addr,
  output logic              ver_ready,
  output logic              chk_done,
  output logic              chk_mismatch,
  output logic              err_sticky,
  output logic [CW-1:0]     occupancy
);
  lvq_fire_t         fire;
  logic [AW-1:0]     wptr, rptr, vptr;
  logic [ADDR_W-1:0] fwd_addr;

  lvq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush),
    .enq_valid(enq_valid), .disp_req(disp_req), .ver_valid(ver_valid),
    .fire(fire), .wptr(wptr), .rptr(rptr), .vptr(vptr),
    .enq_ready(enq_ready), .disp_ready(disp_ready), .ver_ready(ver_ready),
    .occupancy(occupancy)
  );

  lvq_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_val_ram (
    .clk(clk), .we(fire.enq), .waddr(wptr), .wdata(enq_value),
    .re(fire.disp), .raddr(rptr), .rdata(disp_value)
  );

  lvq_ram #(.W(ADDR_W), .DEPTH(DEPTH)) u_addr_ram (
    .clk(clk), .we(fire.enq), .waddr(wptr), .wdata(enq_addr),
    .re(fire.ver), .raddr(vptr), .rdata(fwd_addr)
  );

  lvq_check #(.ADDR_W(ADDR_W)) u_check (
    .clk(clk), .rst(rst), .flush(flush), .start(fire.ver),
    .fwd_addr(fwd_addr), .trl_addr(ver_addr),
    .chk_done(chk_done), .chk_mismatch(chk_mismatch), .err_sticky(err_sticky)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) disp_vld <= 1'b0;
    else              disp_vld <= fire.disp;
  end
endmodule

// File: rtl/lvq_chk.sv
module lvq_chk #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          enq_ready,
  input logic          disp_req,
  input logic          disp_ready,
  input logic          disp_vld,
  input logic          ver_ready,
  input logic          err_sticky,
  input logic [CW-1:0] occupancy
);
  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (occupancy == CW'(DEPTH)) |-> !enq_ready);

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= CW'(DEPTH));

  // R2
  disp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    disp_vld |-> $past(disp_req && disp_ready && !flush));

  // R3
  empty_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (occupancy == '0) |-> (!disp_ready && !ver_ready));

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && !flush) |=> err_sticky);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occupancy == '0 && !disp_vld && !err_sticky));
endmodule

bind fwd_load_queue lvq_chk #(.DEPTH(DEPTH)) u_lvq_chk (
  .clk(clk), .rst(rst), .flush(flush), .enq_ready(enq_ready),
  .disp_req(disp_req), .disp_ready(disp_ready), .disp_vld(disp_vld),
  .ver_ready(ver_ready), .err_sticky(err_sticky), .occupancy(occupancy)
);

// File: tb/sim_fwd_load_queue.sv
`timescale 1ns/1ps
module sim_fwd_load_queue;
  localparam int DEPTH = 128;
  localparam int DW    = 32;
  localparam int AWD   = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rst = 1, flush = 0;
  logic enq_valid = 0, disp_req = 0, ver_valid = 0;
  logic [DW-1:0]  enq_value = '0;
  logic [AWD-1:0] enq_addr = '0, ver_addr = '0;
  logic enq_ready, disp_ready, disp_vld, ver_ready;
  logic chk_done, chk_mismatch, err_sticky;
  logic [DW-1:0] disp_value;
  logic [CW-1:0] occupancy;

  always #2.5 clk = ~clk;

  fwd_load_queue #(.DEPTH(DEPTH), .DATA_W(DW), .ADDR_W(AWD)) u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .enq_valid(enq_valid), .enq_value(enq_value), .enq_addr(enq_addr), .enq_ready(enq_ready),
    .disp_req(disp_req), .disp_ready(disp_ready), .disp_vld(disp_vld), .disp_value(disp_value),
    .ver_valid(ver_valid), .ver_addr(ver_addr), .ver_ready(ver_ready),
    .chk_done(chk_done), .chk_mismatch(chk_mismatch), .err_sticky(err_sticky),
    .occupancy(occupancy)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // behavioural reference state
  logic [DW-1:0]  m_pv[$];
  logic [AWD-1:0] m_pa[$];
  logic [AWD-1:0] m_ua[$];
  bit m_dvld, m_stg, m_done, m_mis, m_err;
  logic [DW-1:0]  m_dval;
  logic [AWD-1:0] m_sf, m_st;

  function automatic int m_occ();
    return m_pv.size() + m_ua.size();
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit er, dr, vr;
    er = m_occ() < DEPTH;
    dr = m_pv.size() > 0;
    vr = m_ua.size() > 0;
    if (rst || flush) begin
      m_pv.delete(); m_pa.delete(); m_ua.delete();
      m_dvld = 0; m_stg = 0; m_done = 0; m_mis = 0; m_err = 0;
    end else begin
      m_done = m_stg;
      m_mis  = m_stg && (m_sf != m_st);
      if (m_mis) m_err = 1;
      if (ver_valid && vr) begin
        m_stg = 1; m_sf = m_ua.pop_front(); m_st = ver_addr;
      end else m_stg = 0;
      if (disp_req && dr) begin
        m_dvld = 1; m_dval = m_pv.pop_front(); m_ua.push_back(m_pa.pop_front());
      end else m_dvld = 0;
      if (enq_valid && er) begin
        m_pv.push_back(enq_value); m_pa.push_back(enq_addr);
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(enq_ready == (m_occ() < DEPTH), "R7", "enq_ready", enq_ready, m_occ() < DEPTH);
      chk(disp_ready == (m_pv.size() > 0), "R3", "disp_ready", disp_ready, m_pv.size() > 0);
      chk(ver_ready == (m_ua.size() > 0), "R4", "ver_ready", ver_ready, m_ua.size() > 0);
      chk(occupancy == CW'(m_occ()), "R6", "occupancy", occupancy, m_occ());
      chk(disp_vld == m_dvld, "R2", "disp_vld", disp_vld, m_dvld);
      if (m_dvld) chk(disp_value == m_dval, "R2", "disp_value", disp_value, m_dval);
      chk(chk_done == m_done, "R4", "chk_done", chk_done, m_done);
      chk(chk_mismatch == m_mis, "R4", "chk_mismatch", chk_mismatch, m_mis);
      chk(err_sticky == m_err, "R5", "err_sticky", err_sticky, m_err);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input bit e, input bit d, input bit v, input bit bad, input bit f);
    enq_valid = e; enq_value = $urandom; enq_addr = $urandom;
    disp_req = d; ver_valid = v; flush = f;
    ver_addr = (m_ua.size() > 0) ? m_ua[0] : AWD'($urandom);
    if (bad) ver_addr = ver_addr ^ 32'h40;
    @(posedge clk); #1;
  endtask

  initial begin
    int occ0;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    // R1 reset state
    chk(occupancy == 0 && enq_ready && !disp_ready && !ver_ready && !disp_vld &&
        !chk_done && !chk_mismatch && !err_sticky, "R1", "reset state",
        {occupancy, enq_ready, disp_ready, ver_ready, disp_vld, err_sticky}, {8'd0, 5'b10000});
    @(posedge clk); #1;
    rst = 0;

    // R3 dispatch and verify on empty queue are ignored
    repeat (4) cyc(0, 1, 1, 0, 0);
    @(negedge clk);
    chk(!disp_vld && occupancy == 0, "R3", "empty dispatch ignored", disp_vld, 0);
    cyc(1, 0, 0, 0, 0);
    repeat (2) cyc(0, 1, 1, 0, 0);

    // R7 fill past capacity
    repeat (DEPTH + 6) cyc(1, 0, 0, 0, 0);
    @(negedge clk);
    chk(occupancy == CW'(DEPTH) && !enq_ready, "R7", "full backpressure", occupancy, DEPTH);

    // R6 dispatch all: occupancy must not drop
    repeat (DEPTH + 2) cyc(1, 1, 0, 0, 0);
    @(negedge clk);
    chk(occupancy == CW'(DEPTH), "R6", "held until verified", occupancy, DEPTH);

    // R4 verify all, correct addresses
    repeat (DEPTH + 3) cyc(0, 0, 1, 0, 0);
    @(negedge clk);
    chk(occupancy == 0 && !err_sticky, "R4", "all verified clean", occupancy, 0);

    // R9 simultaneous enqueue, dispatch, verify
    repeat (3) cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    @(negedge clk);
    occ0 = occupancy;
    cyc(1, 1, 1, 0, 0);
    @(negedge clk);
    chk(occupancy == CW'(occ0) && disp_vld, "R9", "concurrent fire", occupancy, occ0);

    // R5 a wrong address sets a sticky flag
    cyc(0, 0, 1, 1, 0);
    repeat (2) cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    chk(err_sticky, "R5", "mismatch latched", err_sticky, 1);
    repeat (3) cyc(1, 1, 1, 0, 0);
    @(negedge clk);
    chk(err_sticky, "R5", "flag stays set", err_sticky, 1);

    // R8 flush with traffic in the same cycle
    cyc(1, 1, 1, 0, 1);
    @(negedge clk);
    chk(occupancy == 0 && !err_sticky && !disp_vld, "R8", "flush clears",
        occupancy, 0);

    // random mix with occasional wrong addresses and flushes
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 3) != 0,
          ($urandom % 60) == 0, ($urandom % 400) == 0);
    end
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule